// File: doc/BRIEF.md
# Run-Length Instruction Ownership Decoder

Each processor in a mesh holds a full copy of a loop body and decides, line by line, whether to execute an instruction or only track it. The decision comes from a broadcast bit-string that changes from one iteration to the next. The bit-string is a chain of short words. Each word pairs a processor number with a count of consecutive instruction lines. This block turns that chain into an owner for the line the local fetch unit is currently on. It raises an execute flag when the owner is this processor.

The fetch unit pulses a restart at the top of every iteration. On that pulse the block captures the bit-string, so a later broadcast cannot disturb the iteration in progress. The fetch unit pulses an advance strobe each time it moves to the next line. Words with a zero count are passed over without using up a line. Once every word is spent, the processor named in the final word keeps all the remaining lines.

Top module: `chromo_owner_dec`

## Requirements
- R1: After reset the owner output is 0, and the execute flag is high only when the self ID is 0.
- R2: Word k occupies chromosome bits [k*5 +: 5] (defaults: 2-bit processor field, 3-bit count field, 4 words). Within a word the processor number is bits [4:3] and the count is bits [2:0]. Word 0 governs the first lines of an iteration.
- R3: After a restart, the processor of the first nonzero-count word owns that many lines. Each following word then owns its own count of lines, in ascending word order.
- R4: A word with a count of zero is skipped and owns no line.
- R5: Once all counts are used up, the processor in the last word (index NUM_WORDS-1) owns every further line. This also applies from line 0 when every count is zero.
- R6: The chromosome input is sampled only on the restart pulse. Changing it during an iteration has no effect on ownership.
- R7: A restart resets decoding to line 0 of the new chromosome, even in the middle of an iteration. When a restart and an advance arrive in the same cycle, the restart wins.
- R8: The execute flag is high exactly when the owner output equals the self ID.
- R9: When neither advance nor restart is asserted, the owner output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chromoIn | input | NUM_WORDS*(PROC_BITS+CNT_BITS) | Broadcast chromosome |
| selfId | input | PROC_BITS | This processor's number |
| lineAdv | input | 1 | Fetch has moved to the next instruction line |
| loopRestart | input | 1 | Start of a loop iteration; captures the chromosome |
| execFlag | output | 1 | This processor must execute the current line |
| ownerId | output | PROC_BITS | Processor that owns the current line |

## Verification
The bench builds the decoder with a 2-bit processor field, a 3-bit count field and four words, which is a 2x2 mesh chain 20 bits wide. With these values every word can own up to seven lines and every processor number appears. This makes it possible to run past the end of the chain, to place zero-count words at the head, middle and tail, and to apply a chromosome whose counts are all zero. Expected owners come from a line-indexed walk of the chromosome written in the bench.

// File: rtl/cod_pkg.sv
package cod_pkg;
  typedef struct packed {
    logic load;  // capture chromosome, seek first nonzero word
    logic step;  // consume one line of the current word
    logic hop;   // last line of the current word consumed, seek next word
  } codStrobes_t;
endpackage

// File: rtl/cod_ctrl.sv
module cod_ctrl
  import cod_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineAdv,
  input  logic        loopRestart,
  input  logic        remIsOne,
  input  logic        exhausted,
  output codStrobes_t strb
);
  logic advLive;

  always_comb begin
    advLive   = lineAdv && !loopRestart && !exhausted;
    strb.load = loopRestart;
    strb.step = advLive && !remIsOne;
    strb.hop  = advLive && remIsOne;
  end

  // R7
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.step, strb.hop}));
endmodule

// File: rtl/cod_dpath.sv
module cod_dpath
  import cod_pkg::*;
#(
  parameter int PROC_BITS = 2,
  parameter int CNT_BITS  = 3,
  parameter int NUM_WORDS = 4,
  localparam int WORD_W   = PROC_BITS + CNT_BITS,
  localparam int CHROMO_W = NUM_WORDS * WORD_W,
  localparam int PTR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CHROMO_W-1:0]  chromoIn,
  input  codStrobes_t          strb,
  output logic                 remIsOne,
  output logic                 exhausted,
  output logic [PROC_BITS-1:0] curOwner
);
  logic [CHROMO_W-1:0] chromoReg;
  logic [PTR_W-1:0]    wordPtr;
  logic [CNT_BITS-1:0] remaining;
  logic [CHROMO_W-1:0] srcChromo;
  int                  startIdx;
  logic                found;
  logic [PTR_W-1:0]    foundIdx;
  logic [CNT_BITS-1:0] foundCnt;

  // search for the lowest word at or above startIdx with a nonzero count
  always_comb begin
    srcChromo = strb.load ? chromoIn : chromoReg;
    startIdx  = strb.load ? 0 : int'(wordPtr) + 1;
    found     = 1'b0;
    foundIdx  = '0;
    foundCnt  = '0;
    for (int k = NUM_WORDS - 1; k >= 0; k--) begin
      if (k >= startIdx && srcChromo[k*WORD_W +: CNT_BITS] != '0) begin
        found    = 1'b1;
        foundIdx = PTR_W'(k);
        foundCnt = srcChromo[k*WORD_W +: CNT_BITS];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chromoReg <= '0;
      wordPtr   <= '0;
      remaining <= '0;
      exhausted <= 1'b1;
    end else begin
      if (strb.load) chromoReg <= chromoIn;
      if (strb.load || strb.hop) begin
        if (found) begin
          wordPtr   <= foundIdx;
          remaining <= foundCnt;
          exhausted <= 1'b0;
        end else begin
          exhausted <= 1'b1;
          remaining <= '0;
        end
      end else if (strb.step) begin
        remaining <= remaining - 1'b1;
      end
    end
  end

  always_comb begin
    remIsOne = (remaining == CNT_BITS'(1));
    if (exhausted) curOwner = chromoReg[CHROMO_W-1 -: PROC_BITS];
    else           curOwner = chromoReg[int'(wordPtr)*WORD_W + CNT_BITS +: PROC_BITS];
  end

  // R4
  no_zero_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    !exhausted |-> remaining != '0);

  // R6
  chromo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(chromoReg));

  // R5
  tail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (exhausted && !strb.load) |=> exhausted);

  // R3
  step_same_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> ($stable(wordPtr) && !exhausted));
endmodule

// File: rtl/chromo_owner_dec.sv
module chromo_owner_dec
  import cod_pkg::*;
#(
  parameter int PROC_BITS = 2,
  parameter int CNT_BITS  = 3,
  parameter int NUM_WORDS = 4,
  localparam int CHROMO_W = NUM_WORDS * (PROC_BITS + CNT_BITS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CHROMO_W-1:0]  chromoIn,
  input  logic [PROC_BITS-1:0] selfId,
  input  logic                 lineAdv,
  input  logic                 loopRestart,
  output logic                 execFlag,
  output logic [PROC_BITS-1:0] ownerId
);
  codStrobes_t strb;
  logic        remIsOne;
  logic        exhausted;

  cod_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .lineAdv(lineAdv), .loopRestart(loopRestart),
    .remIsOne(remIsOne), .exhausted(exhausted), .strb(strb)
  );

  cod_dpath #(.PROC_BITS(PROC_BITS), .CNT_BITS(CNT_BITS), .NUM_WORDS(NUM_WORDS)) dpath_i (
    .clk(clk), .rstN(rstN), .chromoIn(chromoIn), .strb(strb),
    .remIsOne(remIsOne), .exhausted(exhausted), .curOwner(ownerId)
  );

  assign execFlag = (ownerId == selfId);

  // R9
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lineAdv && !loopRestart) |=> $stable(ownerId));
endmodule

// File: tb/chromo_owner_dec_tb_top.sv
module chromo_owner_dec_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] chromoIn = '0;
  logic [1:0]  selfId = '0;
  logic        lineAdv = 1'b0;
  logic        loopRestart = 1'b0;
  logic        execFlag;
  logic [1:0]  ownerId;
  int          nChecks = 0;
  int          nFails = 0;

  always #4 clk = ~clk;

  chromo_owner_dec #(.PROC_BITS(2), .CNT_BITS(3), .NUM_WORDS(4)) dut_i (
    .clk(clk), .rstN(rstN), .chromoIn(chromoIn), .selfId(selfId),
    .lineAdv(lineAdv), .loopRestart(loopRestart), .execFlag(execFlag), .ownerId(ownerId)
  );

  function automatic logic [4:0] wd(int p, int c);
    return {2'(p), 3'(c)};
  endfunction

  function automatic logic [19:0] mk(logic [4:0] w0, logic [4:0] w1, logic [4:0] w2, logic [4:0] w3);
    return {w3, w2, w1, w0};
  endfunction

  // expected owner of a line: walk words in order, tail word takes the rest
  function automatic int expOwner(logic [19:0] c, int line);
    int acc = 0;
    for (int k = 0; k < 4; k++) begin
      int p = int'(c[k*5+3 +: 2]);
      int n = int'(c[k*5 +: 3]);
      if (line < acc + n) return p;
      acc += n;
    end
    return int'(c[19:18]);
  endfunction

  task automatic chk(string tag, int expO);
    logic expE;
    expE = (2'(expO) == selfId);
    nChecks++;
    if (ownerId !== 2'(expO) || execFlag !== expE) begin
      nFails++;
      $display("FAIL %s: owner=%0d exec=%0b expected owner=%0d exec=%0b",
               tag, ownerId, execFlag, expO, expE);
    end
  endtask

  task automatic restartWith(logic [19:0] c, logic adv);
    @(negedge clk);
    chromoIn = c; loopRestart = 1'b1; lineAdv = adv;
    @(negedge clk);
    loopRestart = 1'b0; lineAdv = 1'b0;
  endtask

  task automatic advance();
    lineAdv = 1'b1;
    @(negedge clk);
    lineAdv = 1'b0;
  endtask

  task automatic walk(string tag, logic [19:0] c, int lines);
    restartWith(c, 1'b0);
    for (int l = 0; l < lines; l++) begin
      chk(tag, expOwner(c, l));
      advance();
    end
  endtask

  task automatic testReset();
    selfId = 2'd0; #1;
    chk("R1 reset self0", 0);
    selfId = 2'd2; #1;
    chk("R1 reset self2", 0);
  endtask

  task automatic testBasic();
    selfId = 2'd1;
    // R2 R3: words (2,1)(1,2)(3,1)(0,3), then tail
    walk("R3 basic run", mk(wd(2,1), wd(1,2), wd(3,1), wd(0,3)), 10);
    walk("R2 field layout", mk(wd(3,7), wd(1,1), wd(2,1), wd(1,1)), 10);
  endtask

  task automatic testZeroSkip();
    selfId = 2'd2;
    walk("R4 zero skip", mk(wd(1,0), wd(2,2), wd(3,0), wd(1,1)), 5);
    walk("R4 zero tail", mk(wd(0,1), wd(3,1), wd(2,0), wd(1,0)), 4);
  endtask

  task automatic testAllZero();
    selfId = 2'd3;
    walk("R5 all zero", mk(wd(1,0), wd(2,0), wd(0,0), wd(3,0)), 3);
  endtask

  task automatic testLatch();
    logic [19:0] a;
    a = mk(wd(1,2), wd(2,2), wd(3,2), wd(0,2));
    selfId = 2'd3;
    restartWith(a, 1'b0);
    chk("R6 latch line0", expOwner(a, 0));
    chromoIn = mk(wd(3,7), wd(3,7), wd(3,7), wd(3,7));
    for (int l = 1; l < 9; l++) begin
      advance();
      chk("R6 latch hold", expOwner(a, l));
    end
  endtask

  task automatic testMidRestart();
    logic [19:0] a;
    logic [19:0] b;
    a = mk(wd(0,3), wd(1,3), wd(2,3), wd(3,3));
    b = mk(wd(2,2), wd(0,1), wd(1,1), wd(3,1));
    selfId = 2'd2;
    restartWith(a, 1'b0);
    for (int l = 0; l < 4; l++) advance();
    chk("R7 before restart", expOwner(a, 4));
    restartWith(b, 1'b1);
    chk("R7 restart beats advance", expOwner(b, 0));
    advance();
    chk("R7 after restart line1", expOwner(b, 1));
    advance();
    chk("R7 after restart line2", expOwner(b, 2));
  endtask

  task automatic testHold();
    logic [19:0] a;
    a = mk(wd(1,1), wd(2,1), wd(3,1), wd(0,1));
    selfId = 2'd0;
    restartWith(a, 1'b0);
    advance();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9 hold without advance", expOwner(a, 1));
    end
  endtask

  task automatic testExecFlag();
    for (int s = 0; s < 4; s++) begin
      selfId = 2'(s); #1;
      chk("R8 exec vs self", 2);
    end
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testBasic();
    testZeroSkip();
    testAllZero();
    testLatch();
    testMidRestart();
    testHold();
    testExecFlag();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule